// File: doc/BRIEF.md
# I/O Instruction Handshake Sequencer

This block carries out one two-word input/output instruction against one of 64 device channels. When an instruction is handed over, the block captures both words and the address of the first word. It then steps through four phases: it connects the addressed channel, checks that channel's ready line, moves one word in the requested direction, and disconnects. When the block finishes, it tells the instruction fetch logic how far to advance the program counter.

A flag in the first word chooses what happens when the device is not ready. With the flag set, the block waits in the check phase until the device becomes ready. With the flag clear, the block gives up without a transfer and the next instruction runs. A successful transfer with the flag clear skips the next instruction. A second flag chooses how the second word is used: either it is the data itself, or it holds an operand address that is read or written through a single-cycle memory port.

Top module: `io_seq`

## Requirements
- R1: After reset the block is idle. busy_o, done_o, dev_stb_o and mem_req_o are low and dev_sel_o is all zero.
- R2: The channel number is word1_i[5:0]. While an instruction is in progress and up to its transfer, only dev_sel_o bit [channel] is high, and readiness is taken only from dev_rdy_i[channel].
- R3: With the device ready, busy_o is high for exactly four cycles (connect, check, transfer, disconnect). dev_stb_o pulses once, in the third cycle. In the last cycle done_o is high and dev_sel_o is zero.
- R4: If the wait flag word1_i[6] is 1 for an output or input instruction, the block stays in the check phase while the device is not ready, and transfers once it is ready. busy_o lasts (cycles spent not ready in the check phase) + 4 cycles, and pc_adv_o is 2.
- R5: If the wait flag is 0 and the device is ready, the word is transferred and pc_adv_o is 3.
- R6: If the wait flag is 0 and the device is not ready, busy_o lasts 3 cycles with no strobe and no memory request, and pc_adv_o is 2.
- R7: op_i=2'b10 (or 2'b11) is a test. It never strobes, never requests memory and never stalls, whatever the wait flag. busy_o lasts 3 cycles, and pc_adv_o is 3 if the device is ready and 2 if it is not.
- R8: For an output instruction (op_i=2'b00) with word1_i[10]=0 (immediate mode), dev_dout_o carries word2_i during the strobe and no memory request is made.
- R9: For an output instruction with word1_i[10]=1 (address mode), the block reads memory at {word1_i[9] ? pc_i[14] : 0, word2_i[13:0]} in the strobe cycle and drives the data read onto dev_dout_o.
- R10: For an input instruction (op_i=2'b01) in immediate mode, dev_din_i is written to memory address pc_i+1 (15-bit wrap) in the strobe cycle.
- R11: For an input instruction in address mode, dev_din_i is written to the address formed as in R9.
- R12: start_i and the instruction inputs are ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Instruction present; accepted when idle |
| op_i | input | 2 | 00 output, 01 input, 1x test |
| word1_i | input | 16 | First instruction word (channel, flags) |
| word2_i | input | 16 | Second word: data or operand address |
| pc_i | input | 15 | Address of the first instruction word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Final (disconnect) cycle |
| pc_adv_o | output | 2 | Program counter advance, valid with done_o |
| dev_sel_o | output | 64 | One-hot channel select |
| dev_rdy_i | input | 64 | Per-channel ready lines |
| dev_dout_o | output | 16 | Data to the device |
| dev_din_i | input | 16 | Data from the device |
| dev_stb_o | output | 1 | Transfer strobe |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 15 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid in the request cycle |

## Verification
The assertions check on every cycle that the select lines are at most one-hot, that select is dropped in the done cycle, and that the strobe is a single pulse with a live select. They also check that memory is touched only in the strobe cycle, and that a waiting instruction with an unready device stays in the check phase. Some behaviours only the bench scenarios can show. These are the pc_adv_o values for each outcome, the exact cycle counts, the data and address carried in each mode, the MAP-style upper-bit choice, and that traffic on start_i during a sequence changes nothing.

// File: rtl/io_seq_pkg.sv
package io_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CONN, ST_TEST, ST_XFER, ST_DISC
  } seq_state_e;

  localparam int WAIT_BIT = 6;
  localparam int MAP_BIT  = 9;
  localparam int IND_BIT  = 10;

  localparam logic [1:0] ADV_NORMAL = 2'd2;
  localparam logic [1:0] ADV_SKIP   = 2'd3;
endpackage

// File: rtl/io_seq_decode.sv
module io_seq_decode #(
  parameter int DW = 16,
  parameter int AW = 15,
  parameter int UW = 6
) (
  input  logic [DW-1:0] word1_i,
  input  logic [DW-1:0] word2_i,
  input  logic [AW-1:0] pc_i,
  input  logic [1:0]    op_i,
  output logic [UW-1:0] unit_o,
  output logic          wait_o,
  output logic          ind_o,
  output logic          is_in_o,
  output logic          is_test_o,
  output logic [AW-1:0] addr_o
);
  import io_seq_pkg::*;

  logic [AW-1:0] oper_addr;
  logic [AW-1:0] w2_loc;
  logic          unused_bits;

  assign unit_o    = word1_i[UW-1:0];
  assign wait_o    = word1_i[WAIT_BIT];
  assign ind_o     = word1_i[IND_BIT];
  assign is_test_o = op_i[1];
  assign is_in_o   = (op_i == 2'b01);

  // upper address bit follows PC only when the map flag is set
  assign oper_addr = {word1_i[MAP_BIT] ? pc_i[AW-1] : 1'b0, word2_i[AW-2:0]};
  assign w2_loc    = pc_i + AW'(1);
  assign addr_o    = ind_o ? oper_addr : w2_loc;

  assign unused_bits = ^{word1_i, word2_i};
endmodule

// File: rtl/io_seq_chan.sv
module io_seq_chan #(
  parameter int UNITS = 64,
  parameter int UW    = 6
) (
  input  logic [UW-1:0]    unit_i,
  input  logic             conn_i,
  input  logic [UNITS-1:0] rdy_vec_i,
  output logic [UNITS-1:0] sel_o,
  output logic             rdy_o
);
  for (genvar g = 0; g < UNITS; g++) begin : g_sel
    assign sel_o[g] = conn_i && (unit_i == UW'(g));
  end

  assign rdy_o = rdy_vec_i[unit_i];
endmodule

// File: rtl/io_seq_fsm.sv
module io_seq_fsm
  import io_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rdy_i,
  input  logic       wait_i,
  input  logic       is_test_i,
  output seq_state_e state_o,
  output logic       conn_o,
  output logic       xfer_o,
  output logic       done_o,
  output logic       busy_o,
  output logic [1:0] adv_o
);
  seq_state_e state_q, state_d;
  logic       skip_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_CONN;
      ST_CONN: state_d = ST_TEST;
      ST_TEST: begin
        if (is_test_i)   state_d = ST_DISC;
        else if (rdy_i)  state_d = ST_XFER;
        else if (wait_i) state_d = ST_TEST;
        else             state_d = ST_DISC;
      end
      ST_XFER: state_d = ST_DISC;
      ST_DISC: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      skip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_TEST && state_d != ST_TEST)
        skip_q <= is_test_i ? rdy_i : (rdy_i && !wait_i);
    end
  end

  assign state_o = state_q;
  assign conn_o  = (state_q == ST_CONN) || (state_q == ST_TEST) || (state_q == ST_XFER);
  assign xfer_o  = (state_q == ST_XFER);
  assign done_o  = (state_q == ST_DISC);
  assign busy_o  = (state_q != ST_IDLE);
  assign adv_o   = done_o ? (skip_q ? ADV_SKIP : ADV_NORMAL) : 2'd0;

  // R4
  wait_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TEST && wait_i && !is_test_i && !rdy_i) |=> (state_q == ST_TEST));

  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/io_seq.sv
module io_seq
  import io_seq_pkg::*;
#(
  parameter int UNITS = 64,
  parameter int DW    = 16,
  parameter int AW    = 15,
  localparam int UW   = $clog2(UNITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [DW-1:0]    word1_i,
  input  logic [DW-1:0]    word2_i,
  input  logic [AW-1:0]    pc_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       pc_adv_o,
  output logic [UNITS-1:0] dev_sel_o,
  input  logic [UNITS-1:0] dev_rdy_i,
  output logic [DW-1:0]    dev_dout_o,
  input  logic [DW-1:0]    dev_din_i,
  output logic             dev_stb_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i
);
  logic [DW-1:0] word1_q, word2_q;
  logic [AW-1:0] pc_q;
  logic [1:0]    op_q;
  logic [UW-1:0] unit;
  logic          wait_f, ind_f, is_in, is_test, rdy_sel, conn, xfer, busy;
  logic [AW-1:0] addr;
  seq_state_e    state;

  // R12: capture only when idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word1_q <= '0;
      word2_q <= '0;
      pc_q    <= '0;
      op_q    <= '0;
    end else if (start_i && !busy) begin
      word1_q <= word1_i;
      word2_q <= word2_i;
      pc_q    <= pc_i;
      op_q    <= op_i;
    end
  end

  io_seq_decode #(.DW(DW), .AW(AW), .UW(UW)) u_dec (
    .word1_i(word1_q), .word2_i(word2_q), .pc_i(pc_q), .op_i(op_q),
    .unit_o(unit), .wait_o(wait_f), .ind_o(ind_f), .is_in_o(is_in),
    .is_test_o(is_test), .addr_o(addr)
  );

  io_seq_chan #(.UNITS(UNITS), .UW(UW)) u_chan (
    .unit_i(unit), .conn_i(conn), .rdy_vec_i(dev_rdy_i),
    .sel_o(dev_sel_o), .rdy_o(rdy_sel)
  );

  io_seq_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rdy_i(rdy_sel),
    .wait_i(wait_f), .is_test_i(is_test), .state_o(state), .conn_o(conn),
    .xfer_o(xfer), .done_o(done_o), .busy_o(busy), .adv_o(pc_adv_o)
  );

  assign busy_o      = busy;
  assign dev_stb_o   = xfer;
  assign mem_req_o   = xfer && (is_in || ind_f);
  assign mem_we_o    = xfer && is_in;
  assign mem_addr_o  = mem_req_o ? addr : '0;
  assign mem_wdata_o = mem_we_o ? dev_din_i : '0;
  assign dev_dout_o  = (xfer && !is_in) ? (ind_f ? mem_rdata_i : word2_q) : '0;

  // R2
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_sel_o));

  // R3
  sel_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (dev_sel_o == '0));

  // R3
  stb_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_stb_o |-> ($countones(dev_sel_o) == 1) ##1 !dev_stb_o);

  // R6
  mem_in_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (dev_stb_o && state == ST_XFER));
endmodule

// File: tb/tb_io_seq.sv
module tb_io_seq;
  localparam int CLK_PERIOD = 10;
  localparam int UNITS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [15:0] w1 = '0, w2 = '0;
  logic [14:0] pc = '0;
  logic        busy, done, stb, req, we;
  logic [1:0]  adv;
  logic [63:0] sel, rdy = '0;
  logic [15:0] dout, din = '0, wdata, rdata;
  logic [14:0] maddr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] pat(input logic [14:0] a);
    return {1'b1, a} ^ 16'h5a3c;
  endfunction

  assign rdata = pat(maddr);

  io_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .word1_i(w1), .word2_i(w2), .pc_i(pc), .busy_o(busy), .done_o(done),
    .pc_adv_o(adv), .dev_sel_o(sel), .dev_rdy_i(rdy), .dev_dout_o(dout),
    .dev_din_i(din), .dev_stb_o(stb), .mem_req_o(req), .mem_we_o(we),
    .mem_addr_o(maddr), .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  task automatic check(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
    end
  endtask

  // one instruction; delay = check-phase cycle at which ready rises in wait mode
  task automatic run(input logic [1:0] o, input logic [15:0] a, input logic [15:0] b,
                     input logic [14:0] p, input logic sel_rdy, input int delay,
                     input logic noise);
    logic [5:0]  unit = a[5:0];
    logic        wt = a[6], ind = a[10], tst = o[1], inp = (o == 2'b01);
    logic [14:0] oaddr = {a[9] ? p[14] : 1'b0, b[13:0]};
    logic [14:0] exp_addr;
    logic [63:0] bg = {$urandom, $urandom};
    logic [63:0] sel_c1 = '0;
    int exp_cyc, exp_adv, cyc = 0, nstb = 0, nreq = 0;
    logic [15:0] s_dout = '0, s_wdata = '0, d = 16'($urandom);
    logic [14:0] s_addr = '0;
    logic        s_we = 1'b0, got_done = 1'b0;
    logic [1:0]  s_adv = '0;
    logic [63:0] s_sel_done = '1;

    bg[unit] = sel_rdy;
    @(negedge clk);
    op = o; w1 = a; w2 = b; pc = p; rdy = bg; din = d; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (busy && cyc < 100) begin
      cyc++;
      if (cyc == 1) sel_c1 = sel;
      if (wt && !tst && !sel_rdy && cyc == delay) rdy[unit] = 1'b1;
      if (noise) begin
        start = 1'b1; w1 = 16'($urandom); w2 = 16'($urandom);
        op = 2'($urandom); pc = 15'($urandom);
      end
      if (stb) begin
        nstb++; s_dout = dout;
      end
      if (req) begin
        nreq++; s_addr = maddr; s_we = we; s_wdata = wdata;
      end
      if (done) begin
        got_done = 1'b1; s_adv = adv; s_sel_done = sel; start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;

    if (tst || (!sel_rdy && !wt)) exp_cyc = 3;
    else if (sel_rdy) exp_cyc = 4;
    else exp_cyc = delay + 2;
    if (tst) exp_adv = sel_rdy ? 3 : 2;
    else exp_adv = (sel_rdy && !wt) ? 3 : 2;

    check(noise ? "R12 busy cycles" : "R3/R4/R6/R7 busy cycles", 64'(cyc), 64'(exp_cyc));
    check("R5/R6/R7 pc advance", {63'd0, got_done} << 2 | 64'(s_adv), 64'h4 | 64'(exp_adv));
    check("R2 select during connect", sel_c1, 64'd1 << unit);
    check("R3 select dropped at done", s_sel_done, 64'd0);
    if (tst || (!sel_rdy && !wt)) begin
      check("R6/R7 no strobe", 64'(nstb), 0);
      check("R6/R7 no memory request", 64'(nreq), 0);
    end else begin
      check("R3 single strobe", 64'(nstb), 1);
      exp_addr = ind ? oaddr : 15'(p + 15'd1);
      if (inp) begin
        check(ind ? "R11 write address" : "R10 write address", 64'(s_addr), 64'(exp_addr));
        check(ind ? "R11 write data" : "R10 write data", {47'd0, s_we, s_wdata}, {47'd0, 1'b1, d});
      end else if (ind) begin
        check("R9 read address", 64'(s_addr), 64'(oaddr));
        check("R9 data to device", 64'(s_dout), 64'(pat(oaddr)));
      end else begin
        check("R8 no memory request", 64'(nreq), 0);
        check("R8 data to device", 64'(s_dout), 64'(b));
      end
    end
  endtask

  function automatic logic [15:0] mkw1(input logic [5:0] u, input logic wt,
                                        input logic mp, input logic ind);
    logic [15:0] r = 16'($urandom);
    r[5:0] = u; r[6] = wt; r[9] = mp; r[10] = ind;
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check("R1 busy after reset", 64'(busy), 0);
    check("R1 select after reset", sel, 0);
    check("R1 strobe/req/done after reset", {61'd0, stb, req, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", 64'(busy), 0);

    // directed corner cases
    run(2'b00, mkw1(6'd0,  1'b0, 1'b0, 1'b0), 16'hbeef, 15'h1234, 1'b1, 0, 1'b0); // R5 R8
    run(2'b00, mkw1(6'd63, 1'b0, 1'b1, 1'b1), 16'h3fff, 15'h4000, 1'b1, 0, 1'b0); // R9 map high
    run(2'b00, mkw1(6'd17, 1'b0, 1'b0, 1'b1), 16'hffff, 15'h7fff, 1'b1, 0, 1'b0); // R9 map off
    run(2'b01, mkw1(6'd5,  1'b0, 1'b0, 1'b0), 16'h0000, 15'h7fff, 1'b1, 0, 1'b0); // R10 wrap
    run(2'b01, mkw1(6'd40, 1'b1, 1'b1, 1'b1), 16'h1234, 15'h4321, 1'b0, 7, 1'b0); // R11 R4
    run(2'b00, mkw1(6'd9,  1'b0, 1'b0, 1'b0), 16'h5555, 15'h0100, 1'b0, 0, 1'b0); // R6
    run(2'b10, mkw1(6'd33, 1'b1, 1'b0, 1'b0), 16'h0000, 15'h0200, 1'b0, 3, 1'b0); // R7 no stall
    run(2'b11, mkw1(6'd33, 1'b0, 1'b0, 1'b0), 16'h0000, 15'h0200, 1'b1, 0, 1'b0); // R7 ready
    run(2'b00, mkw1(6'd2,  1'b1, 1'b0, 1'b0), 16'h0f0f, 15'h0300, 1'b1, 0, 1'b0); // R4 already ready
    run(2'b01, mkw1(6'd12, 1'b0, 1'b0, 1'b1), 16'h2222, 15'h0400, 1'b1, 0, 1'b1); // R12 noise

    // constrained random
    for (int i = 0; i < 300; i++) begin
      logic [1:0] o = 2'($urandom);
      run(o, mkw1(6'($urandom), 1'($urandom), 1'($urandom), 1'($urandom)),
          16'($urandom), 15'($urandom), 1'($urandom), 2 + int'($urandom % 8),
          ($urandom % 5) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule